// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Slave with Write-Collision Detection

This block is the slave end of a four-wire serial link (SPI). It oversamples the serial clock, the data input and the active-low select with a faster system clock. It exchanges one byte per transfer, most significant bit first. It supports every combination of clock idle level and clock phase. On the local side, a single-cycle write loads the next byte to send. The last received byte can be read at any time. Two sticky flags report a finished byte and a rejected write.

The phase setting changes the framing.

- **Phase 0:** the select edge starts the byte, and the first bit is put out at once. Data is taken in on the first clock edge of each bit and put out on the second edge. Only one byte may be sent per select assertion. Any write made while the select is low is refused.
- **Phase 1:** the first clock edge starts the byte. Data is put out on the first edge of each bit and taken in on the second edge. Bytes may follow each other with the select held low. A write is refused only while a byte is partly shifted.

The local write side follows a stream-style handshake. `tx_ready_o` tells whether a write made in that cycle will be taken. A write made while `tx_ready_o` is low is not held back or queued. It is dropped, and the collision flag is raised. The receive side has no back-pressure: each finished byte overwrites the read buffer. The pin `miso_oe_o` is the enable for an outside three-state driver. While it is low, the serial output line is meant to float.

Top module: `spi_byte_slave`

## Requirements
- R1: A transfer moves 8 bits in each direction, most significant bit first. The bit counter never exceeds 8. On completion, the received byte appears on `rx_data_o`.
- R2: `cpol_i`=0 means the clock idles low, and `cpol_i`=1 means it idles high. The leading edge of each bit is the one that leaves the idle level. Apart from that, both polarities give the same transfer.
- R3: With `cpha_i`=0, bit 7 of the loaded byte is on `miso_o` after select goes low and before any clock edge. Input bits are taken on leading edges, and the next output bit is presented on each trailing edge.
- R4: With `cpha_i`=1, the first leading edge loads the byte and presents bit 7. Each later leading edge presents the next bit. Input bits are taken on trailing edges.
- R5: With `cpha_i`=0, clock edges after the eighth bit are ignored until select has been released and asserted again.
- R6: With `cpha_i`=1, select may stay low across bytes. The next leading edge starts the next byte from the holding register.
- R7: With `cpha_i`=0, a write made while select is low is refused: the holding register keeps its value, and `wcol_o` becomes 1 in the next cycle.
- R8: With `cpha_i`=1, a write made from the first leading edge of a byte until its eighth trailing edge is refused and sets `wcol_o`.
- R9: `done_o` becomes 1 when the eighth bit has been taken in. A pulse on `clr_i` clears both `done_o` and `wcol_o`. A new set event in the same cycle takes priority over the clear.
- R10: Releasing select discards a partial byte and resets the bit counter. `miso_oe_o` is 0 while select is released, and the next selected byte is exchanged in full.
- R11: `tx_ready_o` is 1 exactly when a write would be taken. A write made while it is 1 loads `wr_data_i` into the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase, which selects the framing |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Enable for the serial output driver |
| wr_i | input | 1 | Local write strobe |
| wr_data_i | input | DW | Byte to be sent next |
| tx_ready_o | output | 1 | A write in this cycle will be taken |
| rx_data_o | output | DW | Last completed received byte |
| done_o | output | 1 | Sticky transfer-complete flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| clr_i | input | 1 | Clears both flags |

## Verification
The assertions assume that `cpol_i` and `cpha_i` change only while select is released. They also assume that the serial clock and data stay steady for several system cycles, so that every synchronized edge lines up with the data it qualifies. The stimulus changes the mode only while select is high. It holds each serial clock level for six system cycles and moves data only on the master's own launch edge. Local writes and clears are single-cycle strobes driven on the falling system-clock edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Qualified serial-clock events, one system cycle wide
  typedef struct packed {
    logic lead;   // edge leaving the idle level
    logic trail;  // edge returning to the idle level
  } sck_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_s,
  input  logic     cpol,
  output sck_evt_t evt
);
  logic sck_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;

  always_comb begin
    evt.lead  = cpol ? fall : rise;
    evt.trail = cpol ? rise : fall;
  end
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sck_evt_t      evt,
  input  logic          sel,
  input  logic          mosi,
  input  logic          cpha,
  input  logic [DW-1:0] load_word,
  output logic          miso,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_p,
  output logic [DW-1:0] rx_word
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] tx_sh, rx_sh, rx_nxt;
  logic [CW-1:0] cnt;
  logic          busy, fin, sel_q;

  assign rx_nxt = {rx_sh[DW-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (!sel) begin
        // released: discard any partial byte
        cnt  <= '0;
        busy <= 1'b0;
        fin  <= 1'b0;
      end else if (!cpha) begin
        if (!sel_q) begin
          // fresh select: first bit goes out before any clock edge
          tx_sh <= load_word;
          cnt   <= '0;
          fin   <= 1'b0;
          busy  <= 1'b1;
        end else if (!fin) begin
          if (evt.lead) begin
            rx_sh <= rx_nxt;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) fin <= 1'b1;
          end
          if (evt.trail && cnt != '0) tx_sh <= tx_sh << 1;
        end
      end else begin
        if (evt.lead) begin
          if (!busy) begin
            tx_sh <= load_word;
            busy  <= 1'b1;
          end else begin
            tx_sh <= tx_sh << 1;
          end
        end
        if (evt.trail && busy) begin
          rx_sh <= rx_nxt;
          if (cnt == LAST) begin
            cnt  <= '0;
            busy <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    if (cpha) done_p = sel && evt.trail && busy && (cnt == LAST);
    else      done_p = sel && sel_q && !fin && evt.lead && (cnt == LAST);
  end

  assign miso    = tx_sh[DW-1];
  assign cnt_o   = cnt;
  assign busy_o  = busy;
  assign rx_word = rx_nxt;
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_n_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          done_o,
  output logic          wcol_o,
  input  logic          clr_i
);
  logic [2:0]    pins_s;
  logic          ss_s, mosi_s, sck_s, sel;
  sck_evt_t      evt;
  logic          shift_bit, busy, done_p;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_word, tx_hold, rx_buf;
  logic          done_q, wcol_q;

  spi_slv_sync #(.N(3), .RST(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, mosi_i, sck_i}), .q(pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;
  assign sel = ~ss_s;

  spi_slv_edge edge_i (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(cpol_i), .evt(evt)
  );

  spi_slv_core #(.DW(DW)) core_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel), .mosi(mosi_s),
    .cpha(cpha_i), .load_word(tx_hold), .miso(shift_bit), .cnt_o(bit_cnt),
    .busy_o(busy), .done_p(done_p), .rx_word(rx_word)
  );

  // phase 0: closed for the whole select; phase 1: closed mid-byte
  assign tx_ready_o = cpha_i ? ~busy : ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= '0;
      rx_buf  <= '0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
    end else begin
      if (wr_i && tx_ready_o) tx_hold <= wr_data_i;
      if (done_p) rx_buf <= rx_word;
      done_q <= done_p | (done_q & ~clr_i);
      wcol_q <= (wr_i & ~tx_ready_o) | (wcol_q & ~clr_i);
    end
  end

  assign miso_oe_o = sel;
  assign miso_o    = sel & shift_bit;
  assign rx_data_o = rx_buf;
  assign done_o    = done_q;
  assign wcol_o    = wcol_q;
endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n_i,
  input logic          miso_oe_o,
  input logic          wr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          tx_ready_o,
  input logic          wcol_o,
  input logic          clr_i,
  input logic [CW-1:0] bit_cnt,
  input logic [DW-1:0] tx_hold
);
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(DW));

  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !tx_ready_o |=> wcol_o);

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !tx_ready_o |=> $stable(tx_hold));

  // R11
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && tx_ready_o |=> tx_hold == $past(wr_data_i));

  // R9
  wcol_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !wr_i |=> !wcol_o);

  // R10
  desel_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_n_i, 2) |-> !miso_oe_o);

  // R10
  desel_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_n_i, 3) |-> bit_cnt == '0);
endmodule

bind spi_byte_slave spi_slv_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n_i), .miso_oe_o(miso_oe_o),
  .wr_i(wr_i), .wr_data_i(wr_data_i), .tx_ready_o(tx_ready_o),
  .wcol_o(wcol_o), .clr_i(clr_i), .bit_cnt(bit_cnt), .tx_hold(tx_hold)
);

// File: tb/spi_byte_slave_tb_top.sv
`timescale 1ns/1ps
module spi_byte_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol_i = 1'b0, cpha_i = 1'b0;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic       miso_o, miso_oe_o;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tx_ready_o;
  logic [7:0] rx_data_o;
  logic       done_o, wcol_o;
  logic       clr_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  spi_byte_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .done_o(done_o), .wcol_o(wcol_o), .clr_i(clr_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol_i = pol; cpha_i = pha; sck_i = pol;
    #60;
  endtask

  task automatic sel(input logic v);
    ss_n_i = v;
    #60;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    @(negedge clk);
  endtask

  // master shifts bits [from..to] (0 = MSB) of mo, collects slave bits in mi
  task automatic xbits(input logic [7:0] mo, input int from, input int to,
                       inout logic [7:0] mi);
    for (int i = from; i <= to; i++) begin
      if (!cpha_i) begin
        mosi_i = mo[7-i];
        #30; mi[7-i] = miso_o; sck_i = ~sck_i;
        #30; sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i; mosi_i = mo[7-i];
        #30; mi[7-i] = miso_o; sck_i = ~sck_i;
        #30;
      end
    end
    #30;
  endtask

  task automatic t_reset();
    chk("R9 done after reset", done_o, 0);
    chk("R9 wcol after reset", wcol_o, 0);
    chk("R10 oe after reset", miso_oe_o, 0);
    chk("R1 rx after reset", rx_data_o, 0);
    chk("R11 ready after reset", tx_ready_o, 1);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tx, mo, mi;
      tx = 8'h3A + 8'(m * 8'h29); mo = 8'hC5 - 8'(m * 8'h13); mi = '0;
      set_mode(m[1], m[0]);
      clr();
      wr(tx);
      sel(1'b0);
      chk("R10 oe while selected", miso_oe_o, 1);
      if (!m[0]) chk("R3 first bit before edges", miso_o, tx[7]);
      xbits(mo, 0, 7, mi);
      chk(m[0] ? "R4 slave byte" : "R3 slave byte", mi, tx);
      chk(m[1] ? "R2 idle-high receive" : "R2 idle-low receive", rx_data_o, mo);
      chk("R1 received byte", rx_data_o, mo);
      chk("R9 done set", done_o, 1);
      sel(1'b1);
    end
    clr();
    chk("R9 clear", done_o, 0);
  endtask

  task automatic t_p0_wcol();
    logic [7:0] mi = '0;
    set_mode(0, 0); clr();
    wr(8'h3C);
    sel(1'b0);
    chk("R11 ready low while selected", tx_ready_o, 0);
    wr(8'hFF);
    chk("R7 wcol raised", wcol_o, 1);
    xbits(8'h12, 0, 7, mi);
    chk("R7 rejected write not sent", mi, 8'h3C);
    sel(1'b1);
    chk("R11 ready after release", tx_ready_o, 1);
    clr();
    chk("R9 wcol cleared", wcol_o, 0);
  endtask

  task automatic t_p0_one_byte();
    logic [7:0] mi = '0;
    set_mode(1, 0); clr();
    wr(8'h55);
    sel(1'b0);
    xbits(8'h81, 0, 7, mi);
    chk("R5 first byte", rx_data_o, 8'h81);
    clr();
    xbits(8'h7E, 0, 7, mi);
    chk("R5 no second byte done", done_o, 0);
    chk("R5 rx kept", rx_data_o, 8'h81);
    sel(1'b1);
  endtask

  task automatic t_p1_b2b();
    logic [7:0] mi = '0;
    set_mode(0, 1); clr();
    wr(8'h11);
    sel(1'b0);
    xbits(8'hC3, 0, 7, mi);
    chk("R6 first slave byte", mi, 8'h11);
    chk("R11 ready between bytes", tx_ready_o, 1);
    wr(8'h22);
    chk("R8 no wcol between bytes", wcol_o, 0);
    xbits(8'h5A, 0, 7, mi);
    chk("R6 second slave byte", mi, 8'h22);
    chk("R6 second received byte", rx_data_o, 8'h5A);
    sel(1'b1);
  endtask

  task automatic t_p1_wcol();
    logic [7:0] mi = '0;
    set_mode(1, 1); clr();
    wr(8'h66);
    sel(1'b0);
    xbits(8'hF0, 0, 3, mi);
    chk("R8 ready low mid-byte", tx_ready_o, 0);
    chk("R9 done not yet", done_o, 0);
    wr(8'h99);
    chk("R8 wcol raised", wcol_o, 1);
    xbits(8'hF0, 4, 7, mi);
    chk("R8 byte intact", mi, 8'h66);
    xbits(8'h0F, 0, 7, mi);
    chk("R8 rejected write had no effect", mi, 8'h66);
    chk("R4 received", rx_data_o, 8'h0F);
    sel(1'b1);
  endtask

  task automatic t_abort();
    logic [7:0] mi = '0;
    set_mode(0, 0); clr();
    wr(8'hF0);
    sel(1'b0);
    xbits(8'hAA, 0, 2, mi);
    sel(1'b1);
    chk("R10 oe low after release", miso_oe_o, 0);
    chk("R10 miso low after release", miso_o, 0);
    chk("R10 no done on abort", done_o, 0);
    sel(1'b0);
    xbits(8'h0F, 0, 7, mi);
    chk("R10 full byte after abort", rx_data_o, 8'h0F);
    chk("R10 slave byte after abort", mi, 8'hF0);
    sel(1'b1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog all-R act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_modes();
    t_p0_wcol();
    t_p0_one_byte();
    t_p1_b2b();
    t_p1_wcol();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule